// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a virtual address into a physical page base by walking a tree of page table entries held in memory. A requester presents the virtual address, the access kind (load, store or instruction fetch), a privilege flag, the root of the table tree, a translation mode and the size of physical memory, then pulses `start`. The walker reads one entry at a time through a simple request/acknowledge memory port. At each level it either descends through a pointer entry or stops at a leaf.

The translation mode selects the tree shape at run time. Mode 1 has two levels with 10-bit indices and 4-byte entries. Mode 2 has three levels with 9-bit indices and 8-byte entries. Mode 3 has four levels with 9-bit indices and 8-byte entries. A leaf that passes its permission check gets its referenced flag set, plus its dirty flag for stores, and is written back in place. A leaf found above the last level maps a large page: the low virtual page bits fill the physical page number. Any fault is returned as an all-ones page address.

Top module: `pt_walker`

## Requirements
- R1: `mode` 1 walks 2 levels with 10-bit indices and 4-byte entries. `mode` 2 walks 3 levels with 9-bit indices and 8-byte entries. `mode` 3 walks 4 levels with 9-bit indices and 8-byte entries. `mode` 0 returns a fault and makes no memory access.
- R2: The address width is 12 plus levels times index bits. If bits 63 down to width-1 of `vaddr` are neither all zeros nor all ones, the walk faults before any memory access.
- R3: The walk starts at `rootBase` at the top level. The entry address is base + index × entry size, where the index is `vaddr` >> (12 + level × index bits), masked to the index width. `memReq` stays high with `memAddr`/`memWrite` stable until `memAck` is sampled high.
- R4: An entry address at or above `memSize` ends the walk with a fault, and that entry is not read.
- R5: Entry format: bit 0 valid, bit 1 pointer, bit 2 read, bit 3 write, bit 4 execute, bit 5 user, bit 6 referenced, bit 7 dirty, with the page number from bit 10 upward. A valid pointer sets the next base to page number << 12 and descends one level. A pointer at the last level faults. An invalid entry faults.
- R6: A leaf needs execute for a fetch, write for a store and read otherwise. A non-supervisor access also needs the user bit. On failure the walk faults and performs no write.
- R7: A permitted leaf is written back to the same address with the same width, with bit 6 set and, for stores, bit 7 set. All other bits are unchanged.
- R8: The result is (page number OR (vaddr>>12 masked to level × index bits)) << 12. For a leaf at the last level, the masked term is zero.
- R9: A resulting page base at or above `memSize` is a fault. The write-back of R7 still takes place.
- R10: `ready` is high only while idle. `start` is taken when `ready` is high. Each walk ends with `respValid` high for exactly one cycle, with `respPage` set to all ones on a fault. The next cycle returns to idle.
- R11: `memWide` is high for 8-byte entries. A 4-byte entry uses only `memRdata[31:0]` and is written back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken when ready) |
| vaddr | input | 64 | Virtual address to translate |
| isSuper | input | 1 | Access has supervisor privilege |
| isStore | input | 1 | Access is a store |
| isFetch | input | 1 | Access is an instruction fetch |
| rootBase | input | 64 | Physical address of the top-level table |
| mode | input | 2 | Translation scheme select |
| memSize | input | 64 | Bytes of physical memory |
| ready | output | 1 | Walker idle and accepting start |
| respValid | output | 1 | One-cycle result strobe |
| respPage | output | 64 | Physical page base, all ones on fault |
| memReq | output | 1 | Memory request, held until ack |
| memWrite | output | 1 | Request is a write |
| memWide | output | 1 | Entry is 8 bytes (else 4) |
| memAddr | output | 64 | Entry address |
| memWdata | output | 64 | Updated entry for write-back |
| memAck | input | 1 | Memory completes request; read data valid |
| memRdata | input | 64 | Entry read data |

## Verification
The assertions assume that `memSize` stays constant while a walk is in progress. Under that assumption, every issued address can be checked against the live `memSize` port. They also assume that `memAck` only answers a pending request. The bench's memory model acknowledges exactly one request at a time, one cycle after it appears. The bench changes `memSize` and the mode inputs only while the walker is idle. Table contents cover pointer chains, large-page leaves, missing entries, out-of-range entries and out-of-range pages in every mode.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PG_SHIFT  = 12;
  localparam int PPN_SHIFT = 10;
  localparam int B_VALID = 0;
  localparam int B_PTR   = 1;
  localparam int B_RD    = 2;
  localparam int B_WR    = 3;
  localparam int B_EX    = 4;
  localparam int B_USER  = 5;
  localparam int B_REF   = 6;
  localparam int B_DIRTY = 7;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_L2   = 2'd1,
    MODE_L3   = 2'd2,
    MODE_L4   = 2'd3
  } ptwMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic latchPte;
    logic descend;
    logic markFault;
    logic markPage;
  } ptwCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic cfgOk;
    logic entryOob;
    logic isPointer;
    logic atLastLevel;
    logic permOk;
    logic pageOob;
  } ptwStat_t;

  function automatic logic leafAllowed(input logic [63:0] pte, input logic sup,
                                       input logic st, input logic fe);
    logic need;
    need = fe ? pte[B_EX] : (st ? pte[B_WR] : pte[B_RD]);
    return pte[B_VALID] && !pte[B_PTR] && need && (sup || pte[B_USER]);
  endfunction
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  ptwCtl_t         ctl,
  input  logic [XLEN-1:0] vaddr,
  input  logic            isSuper,
  input  logic            isStore,
  input  logic            isFetch,
  input  logic [XLEN-1:0] rootBase,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] memSize,
  input  logic [63:0]     memRdata,
  output ptwStat_t        stat,
  output logic [XLEN-1:0] memAddr,
  output logic [63:0]     memWdata,
  output logic            memWide,
  output logic [XLEN-1:0] respPage
);
  localparam int SHW = $clog2(XLEN) + 1;

  logic [XLEN-1:0] vaR, baseR, memSizeR, resultR;
  logic [63:0]     pteR;
  logic [1:0]      modeR, levelR;
  logic            supR, storeR, fetchR;

  logic [2:0]      lvCount;
  logic [3:0]      idxBits;
  logic            modeOk;
  logic [SHW-1:0]  ptShift, vaBits;
  logic [XLEN-1:0] topMask, idxMask, index, entryAddr;
  logic [XLEN-1:0] ppn, lowVpn, pageBase;
  logic [63:0]     wbEntry;
  logic            canon;

  function automatic logic [1:0] topLevel(input logic [1:0] m);
    case (m)
      MODE_L2: return 2'd1;
      MODE_L3: return 2'd2;
      MODE_L4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // geometry chosen by the latched mode
  always_comb begin
    modeOk  = 1'b1;
    memWide = 1'b1;
    lvCount = 3'd3;
    idxBits = 4'd9;
    case (modeR)
      MODE_L2: begin lvCount = 3'd2; idxBits = 4'd10; memWide = 1'b0; end
      MODE_L3: begin lvCount = 3'd3; idxBits = 4'd9; end
      MODE_L4: begin lvCount = 3'd4; idxBits = 4'd9; end
      default: modeOk = 1'b0;
    endcase
  end

  always_comb begin
    ptShift   = SHW'(levelR) * SHW'(idxBits);
    vaBits    = SHW'(PG_SHIFT) + SHW'(lvCount) * SHW'(idxBits);
    topMask   = {XLEN{1'b1}} << (vaBits - SHW'(1));
    canon     = ((vaR & topMask) == '0) || ((vaR & topMask) == topMask);
    idxMask   = (XLEN'(1) << idxBits) - XLEN'(1);
    index     = (vaR >> (SHW'(PG_SHIFT) + ptShift)) & idxMask;
    entryAddr = baseR + (memWide ? (index << 3) : (index << 2));
    ppn       = XLEN'(pteR >> PPN_SHIFT);
    lowVpn    = (vaR >> PG_SHIFT) & ((XLEN'(1) << ptShift) - XLEN'(1));
    pageBase  = (ppn | lowVpn) << PG_SHIFT;
    wbEntry   = pteR;
    wbEntry[B_REF] = 1'b1;
    if (storeR) wbEntry[B_DIRTY] = 1'b1;
  end

  assign stat.cfgOk       = modeOk && canon;
  assign stat.entryOob    = entryAddr >= memSizeR;
  assign stat.isPointer   = pteR[B_VALID] && pteR[B_PTR];
  assign stat.atLastLevel = (levelR == 2'd0);
  assign stat.permOk      = leafAllowed(pteR, supR, storeR, fetchR);
  assign stat.pageOob     = pageBase >= memSizeR;

  assign memAddr  = entryAddr;
  assign memWdata = memWide ? wbEntry : {32'd0, wbEntry[31:0]};
  assign respPage = resultR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR      <= '0;
      baseR    <= '0;
      memSizeR <= '0;
      resultR  <= '1;
      pteR     <= '0;
      modeR    <= '0;
      levelR   <= '0;
      supR     <= 1'b0;
      storeR   <= 1'b0;
      fetchR   <= 1'b0;
    end else begin
      if (ctl.load) begin
        vaR      <= vaddr;
        baseR    <= rootBase;
        memSizeR <= memSize;
        modeR    <= mode;
        levelR   <= topLevel(mode);
        supR     <= isSuper;
        storeR   <= isStore && !isFetch;
        fetchR   <= isFetch;
      end
      if (ctl.latchPte) pteR <= memWide ? memRdata : {32'd0, memRdata[31:0]};
      if (ctl.descend) begin
        baseR  <= ppn << PG_SHIFT;
        levelR <= levelR - 2'd1;
      end
      if (ctl.markFault)     resultR <= '1;
      else if (ctl.markPage) resultR <= pageBase;
    end
  end
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memAck,
  input  ptwStat_t stat,
  output ptwCtl_t  ctl,
  output logic     ready,
  output logic     respValid,
  output logic     memReq,
  output logic     memWrite
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_FETCH, ST_DECODE, ST_UPDATE, ST_FINISH
  } ptwState_e;

  ptwState_e state, stateNxt;

  always_comb begin
    stateNxt  = state;
    ctl       = '0;
    ready     = 1'b0;
    respValid = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    case (state)
      ST_IDLE: begin
        ready = 1'b1;
        if (start) begin
          ctl.load = 1'b1;
          stateNxt = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (!stat.cfgOk || stat.entryOob) begin
          ctl.markFault = 1'b1;
          stateNxt      = ST_FINISH;
        end else begin
          stateNxt = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.latchPte = 1'b1;
          stateNxt     = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (stat.isPointer) begin
          if (stat.atLastLevel) begin
            ctl.markFault = 1'b1;
            stateNxt      = ST_FINISH;
          end else begin
            ctl.descend = 1'b1;
            stateNxt    = ST_LOOKUP;
          end
        end else if (stat.permOk) begin
          stateNxt = ST_UPDATE;
        end else begin
          ctl.markFault = 1'b1;
          stateNxt      = ST_FINISH;
        end
      end
      ST_UPDATE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) begin
          if (stat.pageOob) ctl.markFault = 1'b1;
          else              ctl.markPage  = 1'b1;
          stateNxt = ST_FINISH;
        end
      end
      ST_FINISH: begin
        respValid = 1'b1;
        stateNxt  = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [XLEN-1:0] vaddr,
  input  logic            isSuper,
  input  logic            isStore,
  input  logic            isFetch,
  input  logic [XLEN-1:0] rootBase,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] memSize,
  output logic            ready,
  output logic            respValid,
  output logic [XLEN-1:0] respPage,
  output logic            memReq,
  output logic            memWrite,
  output logic            memWide,
  output logic [XLEN-1:0] memAddr,
  output logic [63:0]     memWdata,
  input  logic            memAck,
  input  logic [63:0]     memRdata
);
  ptwCtl_t  ctl;
  ptwStat_t stat;

  ptw_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck), .stat(stat),
    .ctl(ctl), .ready(ready), .respValid(respValid), .memReq(memReq),
    .memWrite(memWrite)
  );

  ptw_datapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vaddr(vaddr), .isSuper(isSuper),
    .isStore(isStore), .isFetch(isFetch), .rootBase(rootBase), .mode(mode),
    .memSize(memSize), .memRdata(memRdata), .stat(stat), .memAddr(memAddr),
    .memWdata(memWdata), .memWide(memWide), .respPage(respPage)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            ready,
  input logic            respValid,
  input logic            memReq,
  input logic            memWrite,
  input logic [XLEN-1:0] memAddr,
  input logic [63:0]     memWdata,
  input logic            memAck,
  input logic [XLEN-1:0] memSize
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite));

  a_r4_addr_in_bounds: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr < memSize);

  a_r7_wb_sets_ref: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite |-> memWdata[6]);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && ready);

  a_r10_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    start && ready |=> !ready);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !memReq && !respValid);
endmodule

bind pt_walker pt_walker_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .ready(ready), .respValid(respValid),
  .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .memSize(memSize)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0, rootBase = '0, memSize = 64'h10_0000;
  logic        isSuper = 1'b0, isStore = 1'b0, isFetch = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        ready, respValid, memReq, memWrite, memWide, memAck = 1'b0;
  logic [63:0] respPage, memAddr, memWdata, memRdata = '0;

  int checks = 0, fails = 0, writes = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr), .isSuper(isSuper),
    .isStore(isStore), .isFetch(isFetch), .rootBase(rootBase), .mode(mode),
    .memSize(memSize), .ready(ready), .respValid(respValid), .respPage(respPage),
    .memReq(memReq), .memWrite(memWrite), .memWide(memWide), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // memory model: one acknowledge per request, one cycle after it appears
  always @(negedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWrite) begin
        mem[memAddr] = memWide ? memWdata : {32'd0, memWdata[31:0]};
        writes++;
      end else begin
        memRdata <= rd(memAddr);
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each response with the queued expectation
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) check("R10 unexpected response", respPage, 64'hx);
      else check(tagQ.pop_front(), respPage, expQ.pop_front());
    end
  end

  // requirement model of a walk
  task automatic model(input logic [63:0] va, input logic sup, input logic st,
                       input logic fe, input logic [63:0] root, input logic [1:0] md,
                       output logic [63:0] res, output int nWr,
                       output logic [63:0] wbA, output logic [63:0] wbV);
    int lv, ib, es, vb;
    logic [63:0] base, a, p, hi, ones, pa;
    logic need;
    res = '1; nWr = 0; wbA = '0; wbV = '0;
    case (md)
      2'd1: begin lv = 2; ib = 10; es = 4; end
      2'd2: begin lv = 3; ib = 9;  es = 8; end
      2'd3: begin lv = 4; ib = 9;  es = 8; end
      default: return;
    endcase
    vb = 12 + lv * ib;
    hi = va >> (vb - 1);
    ones = (64'd1 << (64 - vb + 1)) - 1;
    if (hi != 0 && hi != ones) return;
    base = root;
    for (int i = lv - 1; i >= 0; i--) begin
      a = base + ((va >> (12 + i * ib)) & ((64'd1 << ib) - 1)) * es;
      if (a >= memSize) return;
      p = rd(a);
      if (es == 4) p = p & 64'hFFFF_FFFF;
      if (!p[0]) return;
      if (p[1]) begin
        if (i == 0) return;
        base = (p >> 10) << 12;
        continue;
      end
      need = fe ? p[4] : (st ? p[3] : p[2]);
      if (!need || !(sup || p[5])) return;
      nWr = 1; wbA = a; wbV = p | 64'h40 | (st && !fe ? 64'h80 : 64'h0);
      pa = ((p >> 10) | ((va >> 12) & ((64'd1 << (i * ib)) - 1))) << 12;
      if (pa < memSize) res = pa;
      return;
    end
  endtask

  // driver: predicts, queues, starts and waits
  task automatic walk(input string tag, input logic [63:0] va, input logic sup,
                      input logic st, input logic fe, input logic [63:0] root,
                      input logic [1:0] md);
    logic [63:0] res, wbA, wbV;
    int nWr, w0;
    model(va, sup, st, fe, root, md, res, nWr, wbA, wbV);
    expQ.push_back(res);
    tagQ.push_back(tag);
    w0 = writes;
    @(negedge clk);
    while (!ready) @(negedge clk);
    vaddr = va; isSuper = sup; isStore = st; isFetch = fe; rootBase = root; mode = md;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!respValid) @(negedge clk);
    @(negedge clk);
    check({tag, " write count"}, 64'(writes - w0), 64'(nWr));
    if (nWr == 1) check({tag, " written entry"}, rd(wbA), wbV);
  endtask

  function automatic logic [63:0] ptr(input logic [63:0] nxt);
    return ((nxt >> 12) << 10) | 64'h3;
  endfunction
  function automatic logic [63:0] leaf(input logic [63:0] pa, input logic [7:0] fl);
    return ((pa >> 12) << 10) | 64'(fl) | 64'h1;
  endfunction

  localparam logic [63:0] VA4 = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd4 << 12) | 64'h123;
  localparam logic [63:0] VA2 = (64'd1 << 22) | (64'd2 << 12) | 64'h10;

  initial begin
    // four-level chain
    mem[64'h1008] = ptr(64'h2000);
    mem[64'h2010] = ptr(64'h3000);
    mem[64'h3018] = ptr(64'h4000);
    mem[64'h4020] = leaf(64'h50000, 8'h04);
    mem[64'h1800] = leaf(64'h60000, 8'h04);        // top-level large page
    // three-level tables
    mem[64'h8000] = ptr(64'h9000);
    mem[64'h9008] = leaf(64'h0, 8'h04);            // 2 MB page
    mem[64'h9010] = ptr(64'hC000);
    mem[64'hC018] = ptr(64'hD000);                 // pointer at last level
    mem[64'h9020] = leaf(64'h200000, 8'h04);       // page beyond memory
    mem[64'h9028] = ptr(64'hE000);
    mem[64'hE008] = leaf(64'h30000, 8'h0C);
    // two-level, 4-byte entries with junk in the upper half
    mem[64'hA004] = 64'hDEAD_0000_0000_0000 | ptr(64'hB000);
    mem[64'hB008] = 64'hBEEF_0000_0000_0000 | leaf(64'h7000, 8'h30);
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset ready", 64'(ready), 64'd1);
    check("R10 reset respValid", 64'(respValid), 64'd0);
    check("R3 reset memReq", 64'(memReq), 64'd0);

    walk("R1 R3 R8 four-level load", VA4, 1, 0, 0, 64'h1000, 2'd3);
    walk("R6 store to read-only leaf", VA4, 1, 1, 0, 64'h1000, 2'd3);
    walk("R6 user access without user bit", VA4, 0, 0, 0, 64'h1000, 2'd3);
    walk("R2 R8 negative canonical top-level page", 64'hFFFF_8000_0000_0000, 1, 0, 0, 64'h1000, 2'd3);
    walk("R2 non-canonical four-level", 64'h0000_8000_0000_0000, 1, 0, 0, 64'h1000, 2'd3);
    walk("R1 unsupported mode", VA4, 1, 0, 0, 64'h1000, 2'd0);
    walk("R4 root at memory size", VA4, 1, 0, 0, 64'h10_0000, 2'd3);
    walk("R8 three-level large page", (64'd1 << 21) | (64'd5 << 12) | 64'h77, 1, 0, 0, 64'h8000, 2'd2);
    walk("R5 pointer at last level", (64'd2 << 21) | (64'd3 << 12), 1, 0, 0, 64'h8000, 2'd2);
    walk("R5 invalid entry", (64'd3 << 21), 1, 0, 0, 64'h8000, 2'd2);
    walk("R9 page beyond memory", (64'd4 << 21), 1, 0, 0, 64'h8000, 2'd2);
    walk("R7 store sets dirty", (64'd5 << 21) | (64'd1 << 12), 1, 1, 0, 64'h8000, 2'd2);
    walk("R11 R6 two-level user fetch", VA2, 0, 0, 1, 64'hA000, 2'd1);
    walk("R2 non-canonical two-level", 64'h8000_0000, 1, 0, 1, 64'hA000, 2'd1);

    repeat (4) @(negedge clk);
    check("R10 queue drained", 64'(expQ.size()), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule